// File: doc/BRIEF.md
# LPC Firmware-Window Address Remapper

This block sits on the host side of a bridge from LPC firmware-space cycles to an AHB-style system bus. For every firmware address presented with a valid strobe it decides whether the address falls inside a programmable window. It also builds the system-bus address that the cycle should go to. Both results come out of a single register stage.

The window is set by two 32-bit configuration words. Software writes them through a small register port and can read them back. Only the upper half of the address takes part in the decision and the rewrite. In that half, every bit has its own ignore flag for the decode and its own source select for the rewrite, so windows of any power-of-two size can be placed and relocated freely. The lower half of the address is passed through unchanged. LPC serial framing and the system-bus master protocol are handled by neighbouring blocks.

Configuration word layout (the window word is selected by `cfg_sel` = 0, the mask word by `cfg_sel` = 1):
- Window word: bits [31:16] hold the relocation base and bits [15:0] hold the match pattern.
- Mask word: bits [31:16] hold the relocation select and bits [15:0] hold the ignore mask.

Top module: `fw_window_remap`

## Requirements
- R1: After reset, both configuration words read as 0, and `out_valid`, `out_hit` and `out_addr` are 0.
- R2: When `cfg_wr` is high at a clock edge, `cfg_wdata` is stored in the window word if `cfg_sel`=0 and in the mask word if `cfg_sel`=1. `cfg_rdata` always shows the word chosen by `cfg_sel`.
- R3: An address hits only when, for every bit position i in 0..15 whose ignore-mask bit (mask word bit i) is 0, address bit 16+i equals match-pattern bit i (window word bit i).
- R4: On a hit, output address bit 16+i is relocation-base bit i (window word bit 16+i) when relocation-select bit i (mask word bit 16+i) is 1. Otherwise it is address bit 16+i. Output bits [15:0] equal input bits [15:0].
- R5: `out_valid`, `out_hit` and `out_addr` reflect the input that was presented with `in_valid` high exactly one clock earlier.
- R6: A lookup that misses gives `out_valid`=1 and `out_hit`=0, and `out_addr` keeps its previous value.
- R7: A cycle with `in_valid` low gives `out_valid`=0 and `out_hit`=0 one clock later, and `out_addr` is held.
- R8: A lookup presented in the same cycle as a configuration write is judged against the configuration as it stood before that write.
- R9: With window word 0x3000FCE0 and mask word 0xFFE0001F, addresses 0xFCE00000..0xFCFFFFFF hit and map to 0x30000000..0x301FFFFF. With window word 0x30000E00 and mask word 0xFE0001FF, addresses 0x0E000000..0x0FFFFFFF hit and map to 0x30000000..0x31FFFFFF.
- R10: With an ignore mask of 0, only an address whose upper 16 bits equal the match pattern exactly hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 selects the window word, 1 selects the mask word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected configuration word |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 32 | Firmware-space address to decode |
| out_valid | output | 1 | Registered lookup strobe |
| out_hit | output | 1 | Registered hit flag |
| out_addr | output | 32 | Registered relocated address, updated only on a hit |

## Verification
A corrupted configuration word shows up on `cfg_rdata` in the same cycle that the word is selected. It also shows up as a wrong hit flag or a wrong upper address one clock after the first lookup that touches an affected bit. A pipeline register that is stuck or out of phase gives a `out_valid`, `out_hit` or `out_addr` that no longer matches the lookup from one clock earlier, and a reference model compared on every clock reports this on the very next edge. Misses and idle cycles are mixed in between hits, so an address register that wrongly updates on a miss is caught in the cycle it changes.

// File: rtl/fwmap_pkg.sv
package fwmap_pkg;
    localparam int unsigned FWMAP_ADDR_W = 32;
    localparam int unsigned FWMAP_HI_W   = 16;

    typedef enum logic {
        SEL_WINDOW = 1'b0,
        SEL_MASK   = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/fwmap_regs.sv
module fwmap_regs
    import fwmap_pkg::*;
#(
    parameter int unsigned HI_W = FWMAP_HI_W,
    localparam int unsigned CFG_W = 2 * HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [CFG_W-1:0] win_q,
    output logic [CFG_W-1:0] msk_q
);
    typedef struct packed {
        logic [CFG_W-1:0] win;
        logic [CFG_W-1:0] msk;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            if (cfg_sel_e'(sel) == SEL_MASK) cfg_d.msk = wdata;
            else                             cfg_d.win = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign win_q = cfg_q.win;
    assign msk_q = cfg_q.msk;
    assign rdata = (cfg_sel_e'(sel) == SEL_MASK) ? cfg_q.msk : cfg_q.win;
endmodule

// File: rtl/fwmap_match.sv
module fwmap_match
    import fwmap_pkg::*;
#(
    parameter int unsigned ADDR_W = FWMAP_ADDR_W,
    parameter int unsigned HI_W   = FWMAP_HI_W,
    localparam int unsigned LO_W  = ADDR_W - HI_W,
    localparam int unsigned CFG_W = 2 * HI_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  win,
    input  logic [CFG_W-1:0]  msk,
    output logic              hit,
    output logic [ADDR_W-1:0] remapped
);
    logic [HI_W-1:0] addr_hi;
    logic [HI_W-1:0] bit_ok;
    logic [HI_W-1:0] new_hi;

    assign addr_hi = addr[ADDR_W-1 -: HI_W];

    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        // decode: ignored bits always agree
        assign bit_ok[i] = msk[i] | ~(addr_hi[i] ^ win[i]);
        // relocate: select bit picks base over incoming address
        assign new_hi[i] = msk[HI_W + i] ? win[HI_W + i] : addr_hi[i];
    end

    assign hit      = &bit_ok;
    assign remapped = {new_hi, addr[LO_W-1:0]};
endmodule

// File: rtl/fw_window_remap.sv
module fw_window_remap
    import fwmap_pkg::*;
#(
    parameter int unsigned ADDR_W = FWMAP_ADDR_W,
    parameter int unsigned HI_W   = FWMAP_HI_W,
    localparam int unsigned CFG_W = 2 * HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_addr
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [ADDR_W-1:0] addr;
    } pipe_t;

    logic [CFG_W-1:0]  cfg_win;
    logic [CFG_W-1:0]  cfg_msk;
    logic              dec_hit;
    logic [ADDR_W-1:0] dec_addr;
    pipe_t             pipe_d, pipe_q;

    fwmap_regs #(.HI_W(HI_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .win_q (cfg_win),
        .msk_q (cfg_msk)
    );

    fwmap_match #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_match (
        .addr     (in_addr),
        .win      (cfg_win),
        .msk      (cfg_msk),
        .hit      (dec_hit),
        .remapped (dec_addr)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.valid = in_valid;
        pipe_d.hit   = in_valid & dec_hit;
        if (in_valid && dec_hit) pipe_d.addr = dec_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.valid;
    assign out_hit   = pipe_q.hit;
    assign out_addr  = pipe_q.addr;
endmodule

// File: rtl/fwmap_checker.sv
module fwmap_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned HI_W   = 16,
    localparam int unsigned LO_W  = ADDR_W - HI_W,
    localparam int unsigned CFG_W = 2 * HI_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic              out_hit,
    input logic [ADDR_W-1:0] out_addr,
    input logic [CFG_W-1:0]  win,
    input logic [CFG_W-1:0]  msk
);
    AST_VALID_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit)); // R7

    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> $stable(out_addr)); // R6

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_addr[LO_W-1:0] == $past(in_addr[LO_W-1:0]))); // R4

    AST_HIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> ((($past(in_addr[ADDR_W-1 -: HI_W]) ^ $past(win[HI_W-1:0]))
                      & ~$past(msk[HI_W-1:0])) == '0)); // R3
endmodule

bind fw_window_remap fwmap_checker #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .out_valid (out_valid),
    .out_hit   (out_hit),
    .out_addr  (out_addr),
    .win       (cfg_win),
    .msk       (cfg_msk)
);

// File: tb/sim_fw_window_remap.sv
module sim_fw_window_remap;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_hit;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [31:0] m_win = '0;
    logic [31:0] m_msk = '0;
    logic        e_valid = 1'b0;
    logic        e_hit = 1'b0;
    logic [31:0] e_addr = '0;

    fw_window_remap u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_addr  (out_addr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [31:0] a);
        for (int k = 0; k < 16; k++)
            if (m_msk[k] == 1'b0 && a[16 + k] != m_win[k]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] model_map(input logic [31:0] a);
        logic [31:0] r = a;
        for (int k = 0; k < 16; k++)
            if (m_msk[16 + k]) r[16 + k] = m_win[16 + k];
        return r;
    endfunction

    // one clock: drive at falling edge, predict, then compare at the next falling edge
    task automatic step(input string tag, input bit wr, input bit sel, input logic [31:0] wd,
                        input bit v, input logic [31:0] a);
        bit h;
        cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
        in_valid = v; in_addr = a;
        h = v && model_hit(a);               // old configuration (R8)
        e_valid = v;
        e_hit = h;
        if (h) e_addr = model_map(a);
        if (wr) begin
            if (sel) m_msk = wd; else m_win = wd;
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " valid R5"}, {31'd0, out_valid}, {31'd0, e_valid});
        check({tag, " hit R3"}, {31'd0, out_hit}, {31'd0, e_hit});
        check({tag, " addr R4"}, out_addr, e_addr);
        check({tag, " rdata R2"}, cfg_rdata, sel ? m_msk : m_win);
    endtask

    task automatic look(input string tag, input logic [31:0] a);
        step(tag, 1'b0, 1'b0, 32'h0, 1'b1, a);
    endtask

    task automatic wcfg(input string tag, input bit sel, input logic [31:0] d);
        step(tag, 1'b1, sel, d, 1'b0, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 valid", {31'd0, out_valid}, 32'd0);
        check("R1 hit", {31'd0, out_hit}, 32'd0);
        check("R1 addr", out_addr, 32'd0);
        check("R1 window word", cfg_rdata, 32'd0);
        cfg_sel = 1'b1; #1;
        check("R1 mask word", cfg_rdata, 32'd0);
        cfg_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R10: exact match with zero ignore mask
        look("R10 exact", 32'h0000_1234);
        check("R10 exact hit", {31'd0, out_hit}, 32'd1);
        look("R10 near miss", 32'h0001_0000);
        check("R10 miss", {31'd0, out_hit}, 32'd0);

        // R2: writes and readback
        wcfg("R2 win", 1'b0, 32'h3000_FCE0);
        wcfg("R2 msk", 1'b1, 32'hFFE0_001F);
        check("R2 mask readback", cfg_rdata, 32'hFFE0_001F);
        step("R2 sel win", 1'b0, 1'b0, 32'h0, 1'b0, 32'h0);
        check("R2 window readback", cfg_rdata, 32'h3000_FCE0);

        // R9: first window
        look("R9 lo edge", 32'hFCE0_0000);
        check("R9 map lo", out_addr, 32'h3000_0000);
        look("R9 hi edge", 32'hFCFF_FFFF);
        check("R9 map hi", out_addr, 32'h301F_FFFF);
        // R6: misses hold the address
        look("R6 below", 32'hFCDF_FFFF);
        check("R6 held", out_addr, 32'h301F_FFFF);
        look("R6 above", 32'hFD00_0000);
        check("R6 miss flag", {31'd0, out_hit}, 32'd0);
        // R7: idle cycles
        step("R7 idle", 1'b0, 1'b0, 32'h0, 1'b0, 32'hFCE0_0001);
        check("R7 idle valid", {31'd0, out_valid}, 32'd0);
        check("R7 idle addr", out_addr, 32'h301F_FFFF);

        // R8: lookup with a simultaneous write uses the old words
        step("R8 same cycle", 1'b1, 1'b0, 32'h3000_0E00, 1'b1, 32'hFCE1_2345);
        check("R8 old window", out_addr, 32'h3001_2345);
        wcfg("R9 msk2", 1'b1, 32'hFE00_01FF);

        // R9: second window
        look("R9 w2 lo", 32'h0E00_0000);
        check("R9 w2 map lo", out_addr, 32'h3000_0000);
        look("R9 w2 hi", 32'h0FFF_FFFF);
        check("R9 w2 map hi", out_addr, 32'h31FF_FFFF);
        look("R9 w2 above", 32'h1000_0000);
        look("R9 w2 below", 32'h0DFF_FFFF);
        look("R9 w2 mid", 32'h0F12_3456);
        check("R9 w2 map mid", out_addr, 32'h3112_3456);

        // R3/R4: scattered masks, mixed hit, miss and idle pattern
        wcfg("R3 win", 1'b0, 32'hABCD_1234);
        wcfg("R4 msk", 1'b1, 32'h0F0F_00F0);
        for (int n = 0; n < 40; n++) begin
            logic [31:0] a;
            a = {16'h1204 | 16'(n * 16'h0010), 16'(n * 16'h1357)};
            if (n % 5 == 3) a[31:16] = 16'h1334;
            step("R3 sweep", 1'b0, 1'b0, 32'h0, (n % 7) != 6, a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule